// File: doc/BRIEF.md
# Bit-Serial Elastic Store with Pointer-Proximity Alarms

This block is a one-bit-wide elastic store for the receive side of a jitter attenuator. Bits arrive on a write enable that follows the recovered line clock. They leave on a read enable that follows a smoothed clock produced by an external loop. Both enables are qualifiers in a single system clock domain. The usable depth is 32 or 64 positions. A low-bandwidth loop setting always selects the deeper store. After any re-centring, the store holds half its depth of zero bits, so the nominal delay through it is half the selected depth.

The block watches how full the store is and drives two graded alarms. A limit alarm rises when the store is within three positions of empty or of full. A second, tighter alarm rises within two positions. It asks the external loop to widen its bandwidth so that it tracks the input for as long as the condition lasts. A write into a full store, a read from an empty store, or a change of the effective depth re-centres the store.

Top module: `jitter_elastic_fifo`

## Requirements
- R1: After reset both alarms are 0, `rd_bit` is 0, and the store holds half the effective depth of zero bits.
- R2: With `depth_sel`=0 and `narrow_bw`=0 the effective depth is 32: bits are read in write order, and after a re-centre the first written bit is returned by the 17th read.
- R3: With `depth_sel`=1 the effective depth is 64, and after a re-centre the first written bit is returned by the 33rd read.
- R4: With `narrow_bw`=1 the effective depth is 64 whatever `depth_sel` holds.
- R5: `near_limit` is 1 exactly when the fill level (bits written and not yet read) is at most 3 or at least depth minus 3.
- R6: `widen_bw` is 1 exactly when the fill level is at most 2 or at least depth minus 2, and 0 otherwise.
- R7: A write while the store is full and no read is requested discards the written bit and re-centres the store to half depth of zeros; `rd_bit` is unchanged.
- R8: A read while the store is empty re-centres the store (any write in that cycle is discarded) and sets `rd_bit` to 0.
- R9: A change of the effective depth (the OR of `depth_sel` and `narrow_bw`) re-centres the store at the new depth, ignores both enables in that cycle, and leaves `rd_bit` unchanged.
- R10: `rd_bit` changes only on a cycle with `rd_en`=1; it is updated on the clock edge that performs the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write qualifier from the recovered clock |
| wr_bit | input | 1 | Bit to store |
| rd_en | input | 1 | Read qualifier from the smoothed clock |
| depth_sel | input | 1 | 0 selects depth 32, 1 selects depth 64 |
| narrow_bw | input | 1 | Low-bandwidth loop mode; forces depth 64 |
| rd_bit | output | 1 | Last bit read, registered |
| near_limit | output | 1 | Fill level within 3 of empty or full |
| widen_bw | output | 1 | Fill level within 2 of empty or full; request to widen loop bandwidth |

## Verification
The bench builds the block with its default parameters: a 6-bit pointer, which gives depths of 32 and 64, and alarm windows of 3 and 2. With these depths, biased random write and read phases of a few hundred cycles fill and drain the store completely many times. Both edges of each alarm window, overflow and underflow re-centring, and pointer wraparound at both depths are therefore reached routinely. Random depth and bandwidth settings at phase boundaries move the store between the two depths and test the forced-deep mode.

// File: rtl/jitter_elastic_fifo.sv
module jitter_elastic_fifo #(
  parameter int AW        = 6,
  parameter int LIMIT_WIN = 3,
  parameter int WIDEN_WIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic rd_en,
  input  logic depth_sel,
  input  logic narrow_bw,
  output logic rd_bit,
  output logic near_limit,
  output logic widen_bw
);
  localparam int DMAX = 1 << AW;
  localparam int DMIN = DMAX / 2;

  logic [DMAX-1:0] mem;
  logic [AW-1:0]   wptr, rptr, pmask;
  logic [AW:0]     occ, depth, cdepth;
  logic            deep_q, deep_d, cfg_chg, underflow, overflow, recenter;

  assign deep_d    = depth_sel | narrow_bw;
  assign cfg_chg   = deep_d != deep_q;
  assign depth     = deep_q ? (AW+1)'(DMAX) : (AW+1)'(DMIN);
  assign cdepth    = deep_d ? (AW+1)'(DMAX) : (AW+1)'(DMIN);
  assign pmask     = deep_q ? AW'(DMAX - 1) : AW'(DMIN - 1);
  assign underflow = rd_en && occ == '0;
  assign overflow  = wr_en && !rd_en && occ == depth;
  assign recenter  = cfg_chg || underflow || overflow;

  assign near_limit = (int'(occ) <= LIMIT_WIN) || (int'(occ) + LIMIT_WIN >= int'(depth));
  assign widen_bw   = (int'(occ) <= WIDEN_WIN) || (int'(occ) + WIDEN_WIN >= int'(depth));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem    <= '0;
      wptr   <= cdepth[AW:1];
      rptr   <= '0;
      occ    <= {1'b0, cdepth[AW:1]};
      deep_q <= deep_d;
      rd_bit <= 1'b0;
    end else if (recenter) begin
      mem    <= '0;
      wptr   <= cdepth[AW:1];
      rptr   <= '0;
      occ    <= {1'b0, cdepth[AW:1]};
      deep_q <= deep_d;
      if (underflow && !cfg_chg) rd_bit <= 1'b0;
    end else begin
      if (rd_en) begin
        rd_bit <= mem[rptr];
        rptr   <= (rptr + 1'b1) & pmask;
      end
      if (wr_en) begin
        mem[wptr] <= wr_bit;
        wptr      <= (wptr + 1'b1) & pmask;
      end
      occ <= occ + (AW+1)'(wr_en) - (AW+1)'(rd_en);
    end
  end
endmodule

// File: rtl/jitter_elastic_fifo_chk.sv
module jitter_elastic_fifo_chk #(
  parameter int AW = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        narrow_bw,
  input logic        rd_bit,
  input logic        near_limit,
  input logic        widen_bw,
  input logic        deep_q,
  input logic        cfg_chg,
  input logic [AW:0] occ,
  input logic [AW:0] depth
);
  p_widen_in_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    widen_bw |-> near_limit);

  p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= depth);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_bit));

  p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && occ == '0 && !cfg_chg) |=> (rd_bit == 1'b0 && occ == {1'b0, depth[AW:1]}));

  p_cfg_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (!near_limit && !widen_bw));

  p_narrow_deep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_bw |=> deep_q);
endmodule

bind jitter_elastic_fifo jitter_elastic_fifo_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_jitter_elastic_fifo.sv
`timescale 1ns/1ps
module test_jitter_elastic_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_bit = 1'b0, rd_en = 1'b0, depth_sel = 1'b0, narrow_bw = 1'b0;
  logic rd_bit, near_limit, widen_bw;

  int checks = 0;
  int fails  = 0;
  bit q[$];
  bit m_deep = 1'b0;
  bit m_rd   = 1'b0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  jitter_elastic_fifo i_jitter_elastic_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en),
    .depth_sel(depth_sel), .narrow_bw(narrow_bw),
    .rd_bit(rd_bit), .near_limit(near_limit), .widen_bw(widen_bw)
  );

  function automatic int mdepth();
    return m_deep ? 64 : 32;
  endfunction

  function automatic bit exp_limit();
    return q.size() <= 3 || q.size() + 3 >= mdepth();
  endfunction

  function automatic bit exp_widen();
    return q.size() <= 2 || q.size() + 2 >= mdepth();
  endfunction

  task automatic m_recenter();
    q.delete();
    for (int i = 0; i < mdepth() / 2; i++) q.push_back(1'b0);
  endtask

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit w, input bit b, input bit r, input bit ds, input bit nb);
    string tag;
    bit nd;
    @(negedge clk);
    wr_en = w; wr_bit = b; rd_en = r; depth_sel = ds; narrow_bw = nb;
    nd = ds | nb;
    if (nd != m_deep) begin
      m_deep = nd; m_recenter(); tag = "R9";
    end else if (r && q.size() == 0) begin
      m_recenter(); m_rd = 1'b0; tag = "R8";
    end else if (w && !r && q.size() == mdepth()) begin
      m_recenter(); tag = "R7";
    end else begin
      if (r) m_rd = q.pop_front();
      if (w) q.push_back(b);
      tag = !r ? "R10" : (nb ? "R4" : (ds ? "R3" : "R2"));
    end
    @(posedge clk); #1;
    check(rd_bit, m_rd, tag);
    check(near_limit, exp_limit(), "R5 near_limit");
    check(widen_bw, exp_widen(), "R6 widen_bw");
  endtask

  task automatic latency(input bit ds, input bit nb, input int exp_reads, input string tag);
    int n = 0;
    bit seen = 1'b0;
    step(1'b0, 1'b0, 1'b0, ~(ds | nb), 1'b0);
    step(1'b0, 1'b0, 1'b0, ds, nb);
    step(1'b1, 1'b1, 1'b1, ds, nb);
    n = 1;
    for (int i = 0; i < 80 && !seen; i++) begin
      if (rd_bit) seen = 1'b1;
      else begin
        step(1'b1, 1'b0, 1'b1, ds, nb);
        n++;
      end
    end
    checks++;
    if (n != exp_reads) begin
      fails++;
      $display("FAIL %s latency actual=%0d expected=%0d", tag, n, exp_reads);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_deep = 1'b0; m_rd = 1'b0; m_recenter();
    #1;
    check(near_limit, 1'b0, "R1 reset near_limit");
    check(widen_bw, 1'b0, "R1 reset widen_bw");
    check(rd_bit, 1'b0, "R1 reset rd_bit");

    latency(1'b0, 1'b0, 17, "R2");
    latency(1'b1, 1'b0, 33, "R3");
    latency(1'b0, 1'b1, 33, "R4");

    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);

    for (int ph = 0; ph < 60; ph++) begin
      int pw = $urandom_range(10, 90);
      int pr = $urandom_range(10, 90);
      bit ds = ($urandom_range(0, 3) != 0) ? depth_sel : 1'($urandom_range(0, 1));
      bit nb = ($urandom_range(0, 3) != 0) ? narrow_bw : 1'($urandom_range(0, 1));
      for (int c = 0; c < 300; c++) begin
        step(($urandom_range(1, 100) <= pw), 1'($urandom_range(0, 1)),
             ($urandom_range(1, 100) <= pr), ds, nb);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule